// File: doc/BRIEF.md
# Line Fill Buffer for L1 Misses

This block keeps a small pool of entries, each the size of a whole cache line, to track L1 misses for loads and stores. It forms the path between the L1 and the next memory level. A requester presents a line address. If no entry already holds that line, a free entry is taken. If one does, the request joins that entry. A store brings byte-masked data, which is parked in the entry at once, so the requester can move on while the miss is still open.

Each entry sends exactly one request downstream. A store asks for the line in a writable, exclusive state, and a load asks for a read-only copy. When L1 already holds the line shared, a store asks for an upgrade instead, and that upgrade completes on a data-less acknowledgment. When the response arrives, the parked store bytes are laid over the returned bytes. The finished line is then offered to L1, and the entry is released once L1 accepts the write.

Top module: `linefill_buf`

## Requirements
- R1: After reset, `dn_valid` and `l1_valid` are 0, and `req_ready` is 1.
- R2: At most one entry exists per line address. A second request to a busy line joins that entry, and each allocation causes exactly one downstream request.
- R3: The downstream request has `dn_own`=1 when the allocating request was a store (`req_store`=1) and 0 for a load. `l1_excl` carries the same value.
- R4: A store allocated with `req_shared`=1 sends `dn_upgrade`=1 and completes on a response with `rsp_has_data`=0. Its L1 write then has `l1_mask` equal to the OR of all store masks merged into it, and those bytes carry the store data.
- R5: A line returned with `rsp_has_data`=1 is written to L1 with `l1_mask` all ones. Byte b is `l1_data[8b+:8]` and matches `l1_mask[b]` and `req_wmask[b]`. Byte b takes the store byte where any merged store set that mask bit, and the returned byte otherwise.
- R6: Store bytes are accepted while the miss is outstanding. When stores overlap on a byte, the later store's byte wins.
- R7: When every entry is busy, a request for a line without an entry sees `req_ready`=0 until an entry frees.
- R8: `l1_valid`, `l1_line`, `l1_data` and `l1_mask` stay stable until `l1_ready`. The entry is freed on acceptance, and its line can then be requested anew.
- R9: A store to a line whose entry was allocated by a load is held off (`req_ready`=0). Any request to the line currently shown on the L1 port is also held off.
- R10: `dn_valid`, `dn_line`, `dn_own`, `dn_upgrade` and `dn_tag` stay stable until `dn_ready`. A response is addressed by the `dn_tag` of its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Miss request accepted this cycle |
| req_line | input | LADDR_W | Line address |
| req_store | input | 1 | 1 = store (ownership), 0 = load |
| req_shared | input | 1 | L1 holds the line shared (store upgrade) |
| req_wdata | input | LINE_BYTES*8 | Store bytes |
| req_wmask | input | LINE_BYTES | Per-byte store enable |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken |
| dn_line | output | LADDR_W | Requested line |
| dn_tag | output | IDX_W | Entry index carried by the response |
| dn_own | output | 1 | Exclusive (writable) request |
| dn_upgrade | output | 1 | Upgrade only, no data expected |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | IDX_W | Entry addressed |
| rsp_has_data | input | 1 | Response carries the line |
| rsp_data | input | LINE_BYTES*8 | Returned line |
| l1_valid | output | 1 | Line write to L1 valid |
| l1_ready | input | 1 | L1 accepts the write |
| l1_line | output | LADDR_W | Line written |
| l1_data | output | LINE_BYTES*8 | Merged line data |
| l1_mask | output | LINE_BYTES | Bytes to write |
| l1_excl | output | 1 | Install writable |

## Verification
A wrong entry state shows up at the ports in one of three ways. It can appear as a second downstream request for the same line, or as a request-ready value that disagrees with the set of busy lines. It can also appear as an L1 write whose mask or bytes differ from the stores and the returned line. The ready check is made in every cycle in which a request is presented, so a bad allocation or lookup appears within that cycle. A corrupted merge appears at the single L1 write that ends the entry's life, often hundreds of cycles later. For that reason, each write is compared against a per-line model that replays every accepted store and every response.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic [1:0] {
    ENT_IDLE      = 2'd0,
    ENT_REQUESTED = 2'd1,
    ENT_FILLED    = 2'd2,
    ENT_WRITEBACK = 2'd3
  } ent_state_e;
endpackage

// File: rtl/lfb_pick.sv
module lfb_pick #(
  parameter int N     = 10,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lfb_entry.sv
module lfb_entry
  import lfb_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int LADDR_W    = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc,
  input  logic                    merge,
  input  logic                    req_store,
  input  logic                    req_shared,
  input  logic [LADDR_W-1:0]      req_line,
  input  logic [LINE_BYTES*8-1:0] req_wdata,
  input  logic [LINE_BYTES-1:0]   req_wmask,
  input  logic                    sent_set,
  input  logic                    rsp_hit,
  input  logic                    rsp_has_data,
  input  logic [LINE_BYTES*8-1:0] rsp_data,
  input  logic                    wb_start,
  input  logic                    l1_done,
  output ent_state_e              state,
  output logic [LADDR_W-1:0]      line,
  output logic                    own,
  output logic                    upg,
  output logic                    sent,
  output logic                    full,
  output logic [LINE_BYTES*8-1:0] data,
  output logic [LINE_BYTES-1:0]   mask
);
  localparam int DATA_W = LINE_BYTES * 8;

  // bytes of top selected by sel override base
  function automatic logic [DATA_W-1:0] overlay(input logic [DATA_W-1:0] base,
                                                input logic [DATA_W-1:0] top,
                                                input logic [LINE_BYTES-1:0] sel);
    logic [DATA_W-1:0] r;
    r = base;
    for (int b = 0; b < LINE_BYTES; b++)
      if (sel[b]) r[b*8 +: 8] = top[b*8 +: 8];
    return r;
  endfunction

  ent_state_e           state_q, state_d;
  logic [LADDR_W-1:0]   line_q;
  logic                 own_q, upg_q, sent_q, full_q;
  logic [DATA_W-1:0]    data_q, data_d, fill_data;
  logic [LINE_BYTES-1:0] mask_q, mask_d;
  logic                 fill_with_data;

  assign fill_with_data = rsp_hit && rsp_has_data;

  always_comb begin
    fill_data = fill_with_data ? overlay(rsp_data, data_q, mask_q) : data_q;
    if (alloc) begin
      data_d = req_wdata;
      mask_d = req_wmask;
    end else if (merge) begin
      data_d = overlay(fill_data, req_wdata, req_wmask);
      mask_d = mask_q | req_wmask;
    end else begin
      data_d = fill_data;
      mask_d = mask_q;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ENT_IDLE:      if (alloc)    state_d = ENT_REQUESTED;
      ENT_REQUESTED: if (rsp_hit)  state_d = ENT_FILLED;
      ENT_FILLED:    if (wb_start) state_d = ENT_WRITEBACK;
      ENT_WRITEBACK: if (l1_done)  state_d = ENT_IDLE;
      default:                     state_d = ENT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENT_IDLE;
      line_q  <= '0;
      own_q   <= 1'b0;
      upg_q   <= 1'b0;
      sent_q  <= 1'b0;
      full_q  <= 1'b0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
      mask_q  <= mask_d;
      if (alloc) begin
        line_q <= req_line;
        own_q  <= req_store;
        upg_q  <= req_store && req_shared;
        sent_q <= 1'b0;
        full_q <= 1'b0;
      end else begin
        if (sent_set) sent_q <= 1'b1;
        if (rsp_hit)  full_q <= rsp_has_data;
      end
    end
  end

  assign state = state_q;
  assign line  = line_q;
  assign own   = own_q;
  assign upg   = upg_q;
  assign sent  = sent_q;
  assign full  = full_q;
  assign data  = data_q;
  assign mask  = mask_q;

  AST_ALLOC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> state_q == ENT_IDLE) else $error("alloc on busy entry"); // R2
  AST_RSP_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (state_q == ENT_REQUESTED && sent_q)) else $error("response before request"); // R10
  AST_RELEASE_AFTER_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENT_WRITEBACK && l1_done) |=> state_q == ENT_IDLE) else $error("entry not released"); // R8
  AST_SEND_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    sent_set |-> !sent_q) else $error("second downstream request"); // R2
endmodule

// File: rtl/linefill_buf.sv
module linefill_buf
  import lfb_pkg::*;
#(
  parameter int NUM_ENT    = 10,
  parameter int LINE_BYTES = 16,
  parameter int LADDR_W    = 26,
  localparam int IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_line,
  input  logic               req_store,
  input  logic               req_shared,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LINE_BYTES-1:0] req_wmask,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [LADDR_W-1:0] dn_line,
  output logic [IDX_W-1:0]   dn_tag,
  output logic               dn_own,
  output logic               dn_upgrade,
  input  logic               rsp_valid,
  input  logic [IDX_W-1:0]   rsp_tag,
  input  logic               rsp_has_data,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               l1_valid,
  input  logic               l1_ready,
  output logic [LADDR_W-1:0] l1_line,
  output logic [DATA_W-1:0]  l1_data,
  output logic [LINE_BYTES-1:0] l1_mask,
  output logic               l1_excl
);
  ent_state_e            ent_state [NUM_ENT];
  logic [LADDR_W-1:0]    ent_line  [NUM_ENT];
  logic [DATA_W-1:0]     ent_data  [NUM_ENT];
  logic [LINE_BYTES-1:0] ent_mask  [NUM_ENT];
  logic [NUM_ENT-1:0]    ent_own, ent_upg, ent_sent, ent_full;

  logic [NUM_ENT-1:0] hit_vec, free_vec, pend_vec, filled_vec, wb_vec;
  logic [NUM_ENT-1:0] alloc_vec, merge_vec, sent_vec, rsp_vec, wbst_vec, done_vec;

  logic             any_hit, any_free, pend_found, fill_found;
  logic [IDX_W-1:0] hit_idx, free_idx, pend_idx, fill_idx;
  logic             hit_in_wb, hit_needs_own;
  logic             req_fire, dn_fire, l1_fire;

  logic             dn_busy_q, wb_busy_q;
  logic [IDX_W-1:0] dn_idx_q, wb_idx_q;

  // entry status vectors
  always_comb begin
    for (int e = 0; e < NUM_ENT; e++) begin
      free_vec[e]   = ent_state[e] == ENT_IDLE;
      hit_vec[e]    = !free_vec[e] && ent_line[e] == req_line;
      pend_vec[e]   = ent_state[e] == ENT_REQUESTED && !ent_sent[e];
      filled_vec[e] = ent_state[e] == ENT_FILLED;
      wb_vec[e]     = ent_state[e] == ENT_WRITEBACK;
    end
  end

  lfb_pick #(.N(NUM_ENT), .IDX_W(IDX_W)) u_pick_hit  (.cand(hit_vec),    .found(any_hit),    .idx(hit_idx));
  lfb_pick #(.N(NUM_ENT), .IDX_W(IDX_W)) u_pick_free (.cand(free_vec),   .found(any_free),   .idx(free_idx));
  lfb_pick #(.N(NUM_ENT), .IDX_W(IDX_W)) u_pick_pend (.cand(pend_vec),   .found(pend_found), .idx(pend_idx));
  lfb_pick #(.N(NUM_ENT), .IDX_W(IDX_W)) u_pick_fill (.cand(filled_vec), .found(fill_found), .idx(fill_idx));

  // request lookup and back-pressure
  assign hit_in_wb     = |(hit_vec & wb_vec);
  assign hit_needs_own = req_store && |(hit_vec & ~ent_own);
  assign req_ready     = any_hit ? !(hit_in_wb || hit_needs_own) : any_free;
  assign req_fire      = req_valid && req_ready;
  assign dn_fire       = dn_valid && dn_ready;
  assign l1_fire       = l1_valid && l1_ready;

  always_comb begin
    for (int e = 0; e < NUM_ENT; e++) begin
      alloc_vec[e] = req_fire && !any_hit && free_idx == IDX_W'(e);
      merge_vec[e] = req_fire && any_hit && hit_idx == IDX_W'(e);
      sent_vec[e]  = dn_fire && dn_idx_q == IDX_W'(e);
      rsp_vec[e]   = rsp_valid && rsp_tag == IDX_W'(e);
      wbst_vec[e]  = !wb_busy_q && fill_found && fill_idx == IDX_W'(e);
      done_vec[e]  = l1_fire && wb_idx_q == IDX_W'(e);
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    lfb_entry #(.LINE_BYTES(LINE_BYTES), .LADDR_W(LADDR_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_vec[g]), .merge(merge_vec[g]),
      .req_store(req_store), .req_shared(req_shared), .req_line(req_line),
      .req_wdata(req_wdata), .req_wmask(req_wmask),
      .sent_set(sent_vec[g]),
      .rsp_hit(rsp_vec[g]), .rsp_has_data(rsp_has_data), .rsp_data(rsp_data),
      .wb_start(wbst_vec[g]), .l1_done(done_vec[g]),
      .state(ent_state[g]), .line(ent_line[g]), .own(ent_own[g]), .upg(ent_upg[g]),
      .sent(ent_sent[g]), .full(ent_full[g]), .data(ent_data[g]), .mask(ent_mask[g])
    );
  end

  // downstream request holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_busy_q <= 1'b0;
      dn_idx_q  <= '0;
    end else if (dn_fire) begin
      dn_busy_q <= 1'b0;
    end else if (!dn_busy_q && pend_found) begin
      dn_busy_q <= 1'b1;
      dn_idx_q  <= pend_idx;
    end
  end

  assign dn_valid   = dn_busy_q;
  assign dn_tag     = dn_idx_q;
  assign dn_line    = ent_line[dn_idx_q];
  assign dn_own     = ent_own[dn_idx_q];
  assign dn_upgrade = ent_upg[dn_idx_q];

  // L1 write holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_busy_q <= 1'b0;
      wb_idx_q  <= '0;
    end else if (l1_fire) begin
      wb_busy_q <= 1'b0;
    end else if (!wb_busy_q && fill_found) begin
      wb_busy_q <= 1'b1;
      wb_idx_q  <= fill_idx;
    end
  end

  assign l1_valid = wb_busy_q;
  assign l1_line  = ent_line[wb_idx_q];
  assign l1_data  = ent_data[wb_idx_q];
  assign l1_mask  = ent_full[wb_idx_q] ? {LINE_BYTES{1'b1}} : ent_mask[wb_idx_q];
  assign l1_excl  = ent_own[wb_idx_q];

  AST_ONE_ENTRY_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(hit_vec) <= 1) else $error("duplicate line"); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_hit && free_vec == '0) |-> !req_fire) else $error("alloc while full"); // R7
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_line) && $stable(dn_tag) && $stable(dn_own))) else $error("dn changed"); // R10
  AST_L1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_valid && !l1_ready) |=> (l1_valid && $stable(l1_line) && $stable(l1_data) && $stable(l1_mask))) else $error("l1 changed"); // R8
  AST_L1_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    l1_valid |-> $onehot(wb_vec)) else $error("l1 without writeback entry"); // R8
endmodule

// File: tb/linefill_buf_tb_top.sv
`timescale 1ns/1ps
module linefill_buf_tb_top;
  localparam int NE = 10;
  localparam int LB = 16;
  localparam int LA = 26;
  localparam int DW = LB * 8;
  localparam int IW = 4;
  localparam int NL = 14;
  localparam logic [LA-1:0] BASE = 26'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid, req_ready, req_store, req_shared;
  logic [LA-1:0] req_line;
  logic [DW-1:0] req_wdata;
  logic [LB-1:0] req_wmask;
  logic dn_valid, dn_ready, dn_own, dn_upgrade;
  logic [LA-1:0] dn_line;
  logic [IW-1:0] dn_tag;
  logic rsp_valid, rsp_has_data;
  logic [IW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;
  logic l1_valid, l1_ready, l1_excl;
  logic [LA-1:0] l1_line;
  logic [DW-1:0] l1_data;
  logic [LB-1:0] l1_mask;

  linefill_buf #(.NUM_ENT(NE), .LINE_BYTES(LB), .LADDR_W(LA)) dut_i (.*);

  int total = 0;
  int bad = 0;
  bit done = 0;

  // per-line reference model
  bit          m_act [NL];
  bit          m_own [NL];
  bit          m_upg [NL];
  bit          m_full[NL];
  bit          m_sent[NL];
  logic [LB-1:0] m_mask[NL];
  logic [DW-1:0] m_data[NL];
  // responder bookkeeping by tag
  bit          ot_v  [NE];
  bit          ot_upg[NE];

  // bench drive knobs
  bit          drv_v, drv_st, drv_sh;
  int          drv_id;
  logic [DW-1:0] drv_d;
  logic [LB-1:0] drv_m;
  bit          dn_en, rsp_en, l1_en, last_fire;
  bit          p_l1_stall, p_dn_stall;
  logic [LA-1:0] p_l1_line, p_dn_line;
  logic [DW-1:0] p_l1_data;
  logic [IW-1:0] p_dn_tag;

  function automatic logic [DW-1:0] put_bytes(input logic [DW-1:0] under, input logic [DW-1:0] over,
                                              input logic [LB-1:0] m);
    logic [DW-1:0] bm = '0;
    for (int i = 0; i < DW; i++) bm[i] = m[i / 8];
    return (under & ~bm) | (over & bm);
  endfunction

  function automatic int n_active();
    int c = 0;
    for (int i = 0; i < NL; i++) c += m_act[i];
    return c;
  endfunction

  function automatic logic [DW-1:0] rnd_line();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one clock of stimulus and checking, entered and left at a negative edge
  task automatic cycle_once();
    int id;
    int st;
    bit exp_rdy;
    logic [LB-1:0] emask;
    if (p_l1_stall)
      chk(l1_valid && l1_line == p_l1_line && l1_data == p_l1_data, "R8 hold", l1_data, p_l1_data);
    if (p_dn_stall)
      chk(dn_valid && dn_line == p_dn_line && dn_tag == p_dn_tag, "R10 hold", DW'(dn_line), DW'(p_dn_line));
    req_valid  = drv_v;
    req_line   = BASE + LA'(drv_id);
    req_store  = drv_st;
    req_shared = drv_sh;
    req_wdata  = drv_d;
    req_wmask  = drv_m;
    dn_ready   = dn_en && ($urandom % 4 != 0);
    l1_ready   = l1_en && ($urandom % 4 != 0);
    rsp_valid  = 1'b0;
    rsp_tag    = '0;
    rsp_has_data = 1'b0;
    rsp_data   = rnd_line();
    if (rsp_en && ($urandom % 3 == 0)) begin
      st = $urandom % NE;
      for (int k = 0; k < NE; k++) begin
        if (!rsp_valid && ot_v[(st + k) % NE]) begin
          rsp_valid    = 1'b1;
          rsp_tag      = IW'((st + k) % NE);
          rsp_has_data = !ot_upg[(st + k) % NE];
        end
      end
    end
    #1;
    // response arrives: model the fill first
    if (rsp_valid) begin
      ot_v[rsp_tag] = 0;
    end
    // request-ready expectation
    if (drv_v) begin
      if (m_act[drv_id])
        exp_rdy = !(l1_valid && l1_line == req_line) && !(drv_st && !m_own[drv_id]);
      else
        exp_rdy = n_active() < NE;
      if (!m_act[drv_id] && n_active() >= NE)
        chk(req_ready == exp_rdy, "R7 full stall", DW'(req_ready), DW'(exp_rdy));
      else if (m_act[drv_id] && !exp_rdy)
        chk(req_ready == exp_rdy, "R9 join stall", DW'(req_ready), DW'(exp_rdy));
      else
        chk(req_ready == exp_rdy, "R2 join/alloc ready", DW'(req_ready), DW'(exp_rdy));
    end
    last_fire = drv_v && req_ready;
    // downstream request issued
    if (dn_valid && dn_ready) begin
      id = int'(dn_line - BASE);
      if (id < 0 || id >= NL) begin
        chk(0, "R2 unknown line", DW'(dn_line), DW'(BASE));
      end else begin
        chk(m_act[id] && !m_sent[id], "R2 single request", DW'(m_sent[id]), 0);
        chk(dn_own == m_own[id], "R3 own", DW'(dn_own), DW'(m_own[id]));
        chk(dn_upgrade == m_upg[id], "R4 upgrade", DW'(dn_upgrade), DW'(m_upg[id]));
        m_sent[id] = 1;
        ot_v[dn_tag] = 1;
        ot_upg[dn_tag] = dn_upgrade;
      end
    end
    // L1 write accepted
    if (l1_valid && l1_ready) begin
      id = int'(l1_line - BASE);
      if (id < 0 || id >= NL || !m_act[id]) begin
        chk(0, "R8 stray L1 write", DW'(l1_line), DW'(BASE));
      end else begin
        emask = m_full[id] ? '1 : m_mask[id];
        chk(l1_mask == emask, m_full[id] ? "R5 full mask" : "R4 upgrade mask", DW'(l1_mask), DW'(emask));
        chk(put_bytes('0, l1_data, emask) == put_bytes('0, m_data[id], emask), "R6 merged data",
            l1_data, m_data[id]);
        chk(l1_excl == m_own[id], "R3 excl", DW'(l1_excl), DW'(m_own[id]));
        m_act[id] = 0;
      end
    end
    p_l1_stall = l1_valid && !l1_ready;
    p_l1_line  = l1_line;
    p_l1_data  = l1_data;
    p_dn_stall = dn_valid && !dn_ready;
    p_dn_line  = dn_line;
    p_dn_tag   = dn_tag;
    @(posedge clk);
    // state commits at this edge: fill then merge, as in the requirements
    if (rsp_valid) begin
      for (int i = 0; i < NL; i++) begin
        if (m_act[i] && m_sent[i] && BASE + LA'(i) == dn_line_of_tag(rsp_tag)) begin
          m_full[i] = rsp_has_data;
          if (rsp_has_data) m_data[i] = put_bytes(rsp_data, m_data[i], m_mask[i]);
        end
      end
    end
    if (last_fire) begin
      if (m_act[drv_id]) begin
        m_data[drv_id] = put_bytes(m_data[drv_id], drv_d, drv_m);
        m_mask[drv_id] = m_mask[drv_id] | drv_m;
      end else begin
        m_act[drv_id]  = 1;
        m_own[drv_id]  = drv_st;
        m_upg[drv_id]  = drv_st && drv_sh;
        m_full[drv_id] = 0;
        m_sent[drv_id] = 0;
        m_mask[drv_id] = drv_m;
        m_data[drv_id] = drv_d;
      end
      drv_v = 0;
    end
    @(negedge clk);
  endtask

  // tag to line map kept by the responder
  logic [LA-1:0] tag_line [NE];
  function automatic logic [LA-1:0] dn_line_of_tag(input logic [IW-1:0] t);
    return tag_line[t];
  endfunction
  always @(posedge clk) if (dn_valid && dn_ready) tag_line[dn_tag] <= dn_line;

  task automatic set_req(input int id, input bit st, input bit sh, input logic [LB-1:0] m, input logic [DW-1:0] d);
    drv_v = 1; drv_id = id; drv_st = st; drv_sh = sh;
    drv_m = st ? m : '0;
    drv_d = d;
  endtask

  task automatic push(input int id, input bit st, input bit sh, input logic [LB-1:0] m, input logic [DW-1:0] d);
    set_req(id, st, sh, m, d);
    while (drv_v) cycle_once();
  endtask

  task automatic drain();
    dn_en = 1; rsp_en = 1; l1_en = 1;
    for (int c = 0; c < 3000 && n_active() != 0; c++) cycle_once();
    chk(n_active() == 0, "R8 drained", DW'(n_active()), 0);
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    drv_v = 0; drv_id = 0; drv_st = 0; drv_sh = 0; drv_d = '0; drv_m = '0;
    dn_en = 0; rsp_en = 0; l1_en = 0;
    p_l1_stall = 0; p_dn_stall = 0;
    for (int i = 0; i < NL; i++) begin m_act[i] = 0; m_mask[i] = '0; m_data[i] = '0; end
    for (int i = 0; i < NE; i++) ot_v[i] = 0;
    req_valid = 0; req_line = '0; req_store = 0; req_shared = 0; req_wdata = '0; req_wmask = '0;
    dn_ready = 0; l1_ready = 0; rsp_valid = 0; rsp_tag = '0; rsp_has_data = 0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!dn_valid, "R1 dn_valid", DW'(dn_valid), 0);
    chk(!l1_valid, "R1 l1_valid", DW'(l1_valid), 0);
    chk(req_ready, "R1 req_ready", DW'(req_ready), 1);

    // R2 R6: two overlapping stores and a load join one entry
    push(2, 1, 0, 16'h00FF, {16{8'hA1}});
    push(2, 1, 0, 16'h0F0F, {16{8'hB2}});
    push(2, 0, 0, 16'h0000, '0);
    drain();

    // R4: upgrade of a shared line completes without data
    push(3, 1, 1, 16'h000F, {16{8'hC3}});
    push(3, 1, 0, 16'h0300, {16{8'hD4}});
    drain();

    // R9: store held off behind a load entry
    dn_en = 0; rsp_en = 0; l1_en = 0;
    push(4, 0, 0, '0, '0);
    set_req(4, 1, 0, 16'hFFFF, {16{8'h5A}});
    repeat (4) cycle_once();
    chk(drv_v, "R9 store waits on load entry", DW'(drv_v), 1);
    dn_en = 1; rsp_en = 1; l1_en = 1;
    while (drv_v) cycle_once();
    drain();

    // R7: every entry busy, next line stalls until one frees
    dn_en = 0; rsp_en = 0; l1_en = 0;
    for (int i = 0; i < NE; i++) push(i, 1, 0, LB'(1 << i), rnd_line());
    set_req(NE, 1, 0, 16'h8001, rnd_line());
    repeat (5) cycle_once();
    chk(drv_v, "R7 stall while full", DW'(drv_v), 1);
    dn_en = 1; rsp_en = 1; l1_en = 1;
    while (drv_v) cycle_once();
    drain();

    // mixed random traffic
    for (int c = 0; c < 6000; c++) begin
      if (!drv_v && ($urandom % 2 == 0)) begin
        bit st;
        st = ($urandom % 4) != 0;
        set_req($urandom % NL, st, st && ($urandom % 3 == 0), LB'($urandom), rnd_line());
      end
      cycle_once();
    end
    drv_v = 0;
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule